// File: doc/BRIEF.md
# Register Rename Map with Circular Free List

This block renames the architectural register names of decoded instructions onto a larger pool of physical registers. For each instruction it looks up the current physical names of up to two source registers. If the instruction writes a register, the block takes the next physical register from a circular free list, reports it together with the physical register it replaces, and installs it as the newest name for that destination. Every write gets a fresh physical name, so write-after-write and write-after-read hazards on architectural names disappear. Only true data dependences remain. A readiness bit per physical register tells the scheduler whether each source value already exists.

The surrounding pipeline uses four ports. A decode port renames one instruction per cycle. A writeback port marks a physical register as produced. A release port returns a superseded physical register to the free list when the instruction that overwrote it commits. A checkpoint port snapshots the map and the free-list read pointer, and later reloads them so that squashed work is undone.

Top module: `rename_unit`

## Requirements
- R1: After reset, architectural register i maps to physical register i and every physical register reads as ready. The free list holds physical registers ARCH_REGS to PHYS_REGS-1 in ascending order.
- R2: Both sources of a decoded instruction are resolved against the map as it stood before that instruction. A source equal to the instruction's own destination returns the previous physical register.
- R3: A decode with a destination that is not stalled receives the free-list entry at the read pointer on `dec_pdst`. It receives the destination's prior mapping on `dec_pold`. From the next cycle the destination maps to `dec_pdst`.
- R4: A decode without a destination, such as a store or a branch, consumes no free-list entry and leaves the map unchanged.
- R5: `dec_stall` is high exactly when `dec_valid` is high and either a restore is requested or the instruction has a destination while the free list is empty. A stalled decode changes no state.
- R6: Allocation clears the readiness bit of the new physical register, and writeback sets it. When both hit the same register in one cycle, the clear wins. Source readiness also reflects a writeback to that register in the same cycle.
- R7: A release appends the given physical register at the free-list tail. It is handed out only after every entry ahead of it.
- R8: `ckpt_save` records the map and read pointer as they stand after that cycle's decode. `ckpt_restore` reloads both on the next edge and ignores a save in the same cycle. The free-list tail and the readiness bits are not restored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | An instruction is presented for renaming |
| dec_src0 | input | AW (3) | Architectural first source |
| dec_src1 | input | AW (3) | Architectural second source |
| dec_has_dst | input | 1 | The instruction writes a register |
| dec_dst | input | AW (3) | Architectural destination |
| dec_stall | output | 1 | Decode not accepted this cycle |
| dec_psrc0 | output | PW (4) | Physical first source |
| dec_psrc1 | output | PW (4) | Physical second source |
| dec_src0_rdy | output | 1 | First source value already produced |
| dec_src1_rdy | output | 1 | Second source value already produced |
| dec_pdst | output | PW (4) | Newly allocated physical destination |
| dec_pold | output | PW (4) | Physical register superseded by the destination |
| wb_valid | input | 1 | A result is written back |
| wb_preg | input | PW (4) | Physical register written back |
| rel_valid | input | 1 | Return a physical register to the free list |
| rel_preg | input | PW (4) | Physical register returned |
| ckpt_save | input | 1 | Snapshot the map and free-list read pointer |
| ckpt_restore | input | 1 | Reload the snapshot |

## Verification
A corrupted map entry shows on the next decode that reads that architectural register. A wrong free-list pointer or entry shows at the next allocation, as a `dec_pdst` that differs from the FIFO order the bench predicts. A stale readiness bit shows on the first source lookup of that physical register. A bad snapshot shows in the cycle after a restore. Random traffic reads registers often, so any such error reaches the ports within a few cycles of when it arises.

// File: rtl/rename_pkg.sv
package rename_pkg;

  // Physical tag seeded into free-list slot `slot` at reset.
  function automatic int unsigned seed_entry(int unsigned slot, int unsigned arch_regs);
    return arch_regs + slot;
  endfunction

  // Entries held by a ring whose pointers carry one wrap bit (span = 2*depth).
  function automatic int unsigned ring_used(int unsigned head, int unsigned tail,
                                            int unsigned span);
    return (tail + span - head) % span;
  endfunction

  // Pointer advanced by one with wrap over the span.
  function automatic int unsigned ring_step(int unsigned ptr, int unsigned span);
    return (ptr + 1) % span;
  endfunction

endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int ARCH_REGS = 8,
  parameter int PHYS_REGS = 16,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int PW = $clog2(PHYS_REGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_a0,
  input  logic [AW-1:0] rd_a1,
  input  logic [AW-1:0] rd_dst,
  output logic [PW-1:0] rd_p0,
  output logic [PW-1:0] rd_p1,
  output logic [PW-1:0] rd_old,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_a,
  input  logic [PW-1:0] wr_p,
  input  logic          save_en,
  input  logic          restore_en
);
  logic [PW-1:0] cur_q  [ARCH_REGS];
  logic [PW-1:0] snap_q [ARCH_REGS];
  logic [PW-1:0] nxt    [ARCH_REGS];

  assign rd_p0  = cur_q[rd_a0];
  assign rd_p1  = cur_q[rd_a1];
  assign rd_old = cur_q[rd_dst];

  for (genvar g = 0; g < ARCH_REGS; g++) begin : g_entry
    always_comb begin
      nxt[g] = cur_q[g];
      if (restore_en)
        nxt[g] = snap_q[g];
      else if (wr_en && wr_a == AW'(g))
        nxt[g] = wr_p;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cur_q[g]  <= PW'(g);
        snap_q[g] <= PW'(g);
      end else begin
        cur_q[g] <= nxt[g];
        if (save_en && !restore_en)
          snap_q[g] <= nxt[g];
      end
    end
  end
endmodule

// File: rtl/rn_free_ring.sv
module rn_free_ring #(
  parameter int ARCH_REGS = 8,
  parameter int PHYS_REGS = 16,
  localparam int PW   = $clog2(PHYS_REGS),
  localparam int PTW  = PW + 1,
  localparam int SPAN = 2 * PHYS_REGS,
  localparam int SEED = PHYS_REGS - ARCH_REGS
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pop_en,
  output logic [PW-1:0]  pop_tag,
  input  logic           push_en,
  input  logic [PW-1:0]  push_tag,
  input  logic           save_en,
  input  logic           restore_en,
  output logic           empty,
  output logic           full,
  output logic [PTW-1:0] head_ptr,
  output logic [PTW-1:0] snap_ptr
);
  import rename_pkg::*;

  logic [PW-1:0]  mem_q [PHYS_REGS];
  logic [PTW-1:0] head_q, tail_q, snap_q, head_nxt;
  int unsigned    used;

  assign used     = ring_used(32'(head_q), 32'(tail_q), SPAN);
  assign empty    = (used == 0);
  assign full     = (used == PHYS_REGS);
  assign pop_tag  = mem_q[head_q[PW-1:0]];
  assign head_ptr = head_q;
  assign snap_ptr = snap_q;

  always_comb begin
    head_nxt = head_q;
    if (restore_en)
      head_nxt = snap_q;
    else if (pop_en)
      head_nxt = PTW'(ring_step(32'(head_q), SPAN));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= PTW'(SEED);
      snap_q <= '0;
      for (int i = 0; i < PHYS_REGS; i++)
        mem_q[i] <= (i < SEED) ? PW'(seed_entry(unsigned'(i), ARCH_REGS)) : '0;
    end else begin
      head_q <= head_nxt;
      if (save_en && !restore_en)
        snap_q <= head_nxt;
      if (push_en) begin
        mem_q[tail_q[PW-1:0]] <= push_tag;
        tail_q <= PTW'(ring_step(32'(tail_q), SPAN));
      end
    end
  end
endmodule

// File: rtl/rn_ready_vec.sv
module rn_ready_vec #(
  parameter int PHYS_REGS = 16,
  localparam int PW = $clog2(PHYS_REGS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_en,
  input  logic [PW-1:0]        set_tag,
  input  logic                 clr_en,
  input  logic [PW-1:0]        clr_tag,
  input  logic [PW-1:0]        q0,
  input  logic [PW-1:0]        q1,
  output logic                 rdy0,
  output logic                 rdy1,
  output logic [PHYS_REGS-1:0] bits
);
  logic [PHYS_REGS-1:0] rdy_q;

  assign bits = rdy_q;
  assign rdy0 = rdy_q[q0] | (set_en && set_tag == q0);
  assign rdy1 = rdy_q[q1] | (set_en && set_tag == q1);

  for (genvar g = 0; g < PHYS_REGS; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)
        rdy_q[g] <= 1'b1;
      else if (clr_en && clr_tag == PW'(g))
        rdy_q[g] <= 1'b0;
      else if (set_en && set_tag == PW'(g))
        rdy_q[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/rename_unit.sv
module rename_unit #(
  parameter int ARCH_REGS = 8,
  parameter int PHYS_REGS = 16,
  localparam int AW  = $clog2(ARCH_REGS),
  localparam int PW  = $clog2(PHYS_REGS),
  localparam int PTW = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dec_valid,
  input  logic [AW-1:0] dec_src0,
  input  logic [AW-1:0] dec_src1,
  input  logic          dec_has_dst,
  input  logic [AW-1:0] dec_dst,
  output logic          dec_stall,
  output logic [PW-1:0] dec_psrc0,
  output logic [PW-1:0] dec_psrc1,
  output logic          dec_src0_rdy,
  output logic          dec_src1_rdy,
  output logic [PW-1:0] dec_pdst,
  output logic [PW-1:0] dec_pold,
  input  logic          wb_valid,
  input  logic [PW-1:0] wb_preg,
  input  logic          rel_valid,
  input  logic [PW-1:0] rel_preg,
  input  logic          ckpt_save,
  input  logic          ckpt_restore
);
  // Named internal events, observed by the bound checker.
  logic                 alloc_fire;
  logic                 rel_fire;
  logic                 fl_empty;
  logic                 fl_full;
  logic [PTW-1:0]       head_ptr;
  logic [PTW-1:0]       snap_head;
  logic [PHYS_REGS-1:0] rdy_bits;

  assign dec_stall  = dec_valid && (ckpt_restore || (dec_has_dst && fl_empty));
  assign alloc_fire = dec_valid && !dec_stall && dec_has_dst;
  assign rel_fire   = rel_valid && !fl_full;

  rn_map_table #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_map (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_a0      (dec_src0),
    .rd_a1      (dec_src1),
    .rd_dst     (dec_dst),
    .rd_p0      (dec_psrc0),
    .rd_p1      (dec_psrc1),
    .rd_old     (dec_pold),
    .wr_en      (alloc_fire),
    .wr_a       (dec_dst),
    .wr_p       (dec_pdst),
    .save_en    (ckpt_save),
    .restore_en (ckpt_restore)
  );

  rn_free_ring #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_ring (
    .clk        (clk),
    .rst_n      (rst_n),
    .pop_en     (alloc_fire),
    .pop_tag    (dec_pdst),
    .push_en    (rel_fire),
    .push_tag   (rel_preg),
    .save_en    (ckpt_save),
    .restore_en (ckpt_restore),
    .empty      (fl_empty),
    .full       (fl_full),
    .head_ptr   (head_ptr),
    .snap_ptr   (snap_head)
  );

  rn_ready_vec #(.PHYS_REGS(PHYS_REGS)) u_rdy (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (wb_valid),
    .set_tag (wb_preg),
    .clr_en  (alloc_fire),
    .clr_tag (dec_pdst),
    .q0      (dec_psrc0),
    .q1      (dec_psrc1),
    .rdy0    (dec_src0_rdy),
    .rdy1    (dec_src1_rdy),
    .bits    (rdy_bits)
  );
endmodule

// File: rtl/rename_unit_chk.sv
module rename_unit_chk #(
  parameter int ARCH_REGS = 8,
  parameter int PHYS_REGS = 16,
  localparam int PW  = $clog2(PHYS_REGS),
  localparam int PTW = PW + 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 dec_valid,
  input logic                 dec_has_dst,
  input logic                 dec_stall,
  input logic [PW-1:0]        dec_pdst,
  input logic                 wb_valid,
  input logic [PW-1:0]        wb_preg,
  input logic                 rel_valid,
  input logic                 ckpt_restore,
  input logic                 alloc_fire,
  input logic                 fl_empty,
  input logic                 fl_full,
  input logic [PTW-1:0]       head_ptr,
  input logic [PTW-1:0]       snap_head,
  input logic [PHYS_REGS-1:0] rdy_bits
);
  // R5
  stall_blocks_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_stall |-> !alloc_fire);

  // R5
  empty_forces_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_has_dst && fl_empty) |-> dec_stall);

  // R5
  stall_holds_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_stall && !ckpt_restore) |=> head_ptr == $past(head_ptr));

  // R3
  alloc_advances_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |=> head_ptr == PTW'($past(head_ptr) + 1'b1));

  // R6
  alloc_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |=> !rdy_bits[$past(dec_pdst)]);

  // R6
  wb_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !(alloc_fire && dec_pdst == wb_preg)) |=> rdy_bits[$past(wb_preg)]);

  // R8
  restore_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_restore |=> head_ptr == $past(snap_head));

  // R7
  no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |-> !fl_full);
endmodule

bind rename_unit rename_unit_chk #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dec_valid    (dec_valid),
  .dec_has_dst  (dec_has_dst),
  .dec_stall    (dec_stall),
  .dec_pdst     (dec_pdst),
  .wb_valid     (wb_valid),
  .wb_preg      (wb_preg),
  .rel_valid    (rel_valid),
  .ckpt_restore (ckpt_restore),
  .alloc_fire   (alloc_fire),
  .fl_empty     (fl_empty),
  .fl_full      (fl_full),
  .head_ptr     (head_ptr),
  .snap_head    (snap_head),
  .rdy_bits     (rdy_bits)
);

// File: tb/rename_unit_test.sv
`timescale 1ns/1ps
module rename_unit_test;
  localparam int A    = 8;
  localparam int P    = 16;
  localparam int AW   = $clog2(A);
  localparam int PW   = $clog2(P);
  localparam int SPAN = 2 * P;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dec_valid = 0, dec_has_dst = 0, wb_valid = 0, rel_valid = 0;
  logic ckpt_save = 0, ckpt_restore = 0;
  logic [AW-1:0] dec_src0 = '0, dec_src1 = '0, dec_dst = '0;
  logic [PW-1:0] wb_preg = '0, rel_preg = '0;
  logic dec_stall, dec_src0_rdy, dec_src1_rdy;
  logic [PW-1:0] dec_psrc0, dec_psrc1, dec_pdst, dec_pold;

  always #5 clk = ~clk;

  rename_unit #(.ARCH_REGS(A), .PHYS_REGS(P)) uut (
    .clk(clk), .rst_n(rst_n),
    .dec_valid(dec_valid), .dec_src0(dec_src0), .dec_src1(dec_src1),
    .dec_has_dst(dec_has_dst), .dec_dst(dec_dst), .dec_stall(dec_stall),
    .dec_psrc0(dec_psrc0), .dec_psrc1(dec_psrc1),
    .dec_src0_rdy(dec_src0_rdy), .dec_src1_rdy(dec_src1_rdy),
    .dec_pdst(dec_pdst), .dec_pold(dec_pold),
    .wb_valid(wb_valid), .wb_preg(wb_preg),
    .rel_valid(rel_valid), .rel_preg(rel_preg),
    .ckpt_save(ckpt_save), .ckpt_restore(ckpt_restore)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Reference state, written from the requirements.
  int m_map[A];
  int s_map[A];
  int m_fifo[P];
  bit m_rdy[P];
  int m_head, m_tail, s_head;
  int pend[$];

  function automatic int occ();
    return (m_tail - m_head + SPAN) % SPAN;
  endfunction

  function automatic bit rdy_of(int p, bit wb, int wp);
    return m_rdy[p] || (wb && wp == p);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < A; i++) begin m_map[i] = i; s_map[i] = i; end
    for (int i = 0; i < P; i++) begin m_rdy[i] = 1; m_fifo[i] = (i < P - A) ? A + i : 0; end
    m_head = 0; s_head = 0; m_tail = P - A;
    pend.delete();
  endtask

  task automatic step(bit v, int s0, int s1, bit hd, int d, bit wb, int wp,
                      bit rel, int rp, bit sv, bit rs);
    bit xstall, fire;
    int pd;
    @(negedge clk);
    dec_valid = v; dec_src0 = AW'(s0); dec_src1 = AW'(s1);
    dec_has_dst = hd; dec_dst = AW'(d);
    wb_valid = wb; wb_preg = PW'(wp);
    rel_valid = rel; rel_preg = PW'(rp);
    ckpt_save = sv; ckpt_restore = rs;
    #1;
    xstall = v && (rs || (hd && occ() == 0));
    fire   = v && !xstall;
    pd     = m_fifo[m_head % P];
    chk("R5 stall", int'(dec_stall), int'(xstall));
    if (v) begin
      chk("R2 psrc0", int'(dec_psrc0), m_map[s0]);
      chk("R2 psrc1", int'(dec_psrc1), m_map[s1]);
      chk("R6 src0 ready", int'(dec_src0_rdy), int'(rdy_of(m_map[s0], wb, wp)));
      chk("R6 src1 ready", int'(dec_src1_rdy), int'(rdy_of(m_map[s1], wb, wp)));
    end
    if (fire && hd) begin
      chk("R3 pdst", int'(dec_pdst), pd);
      chk("R3 pold", int'(dec_pold), m_map[d]);
      pend.push_back(m_map[d]);
    end
    // next state
    if (wb) m_rdy[wp] = 1;
    if (fire && hd) m_rdy[pd] = 0;
    if (rel && occ() < P) begin
      m_fifo[m_tail % P] = rp;
      m_tail = (m_tail + 1) % SPAN;
    end
    if (rs) begin
      for (int i = 0; i < A; i++) m_map[i] = s_map[i];
      m_head = s_head;
    end else if (fire && hd) begin
      m_map[d] = pd;
      m_head = (m_head + 1) % SPAN;
    end
    if (sv && !rs) begin
      for (int i = 0; i < A; i++) s_map[i] = m_map[i];
      s_head = m_head;
    end
    @(posedge clk);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin : watchdog
    #(200000 * 10);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: identity map and all ready after reset
    step(1, 3, 5, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R1 identity src0", int'(dec_psrc0), 3);
    chk("R1 identity src1", int'(dec_psrc1), 5);
    chk("R1 ready after reset", int'(dec_src0_rdy & dec_src1_rdy), 1);

    // R4: a store-like decode consumes nothing
    step(1, 0, 1, 0, 2, 0, 0, 0, 0, 0, 0);
    // R2: source equal to destination reads the old name
    step(1, 3, 3, 1, 3, 0, 0, 0, 0, 0, 0);
    chk("R2 src sees old map", int'(dec_psrc0), 3);
    chk("R4 first alloc still slot 0", int'(dec_pdst), A);
    chk("R3 pold", int'(dec_pold), 3);

    // R6: new name not ready, then same-cycle writeback bypass
    step(1, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R3 map updated", int'(dec_psrc0), A);
    chk("R6 cleared on alloc", int'(dec_src0_rdy), 0);
    step(1, 3, 0, 0, 0, 1, A, 0, 0, 0, 0);
    chk("R6 writeback bypass", int'(dec_src0_rdy), 1);
    step(1, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R6 set by writeback", int'(dec_src0_rdy), 1);

    // R5: drain the free list, then stall
    for (int k = 0; k < P - A - 1; k++) step(1, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0);
    chk("R5 stall on empty", int'(dec_stall), 1);
    step(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R5 stalled decode left map", int'(dec_psrc0), P - 1);

    // R7: released names come back in FIFO order
    step(0, 0, 0, 0, 0, 0, 0, 1, 5, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 1, 6, 0, 0);
    step(1, 0, 0, 1, 2, 0, 0, 1, 7, 0, 0);
    chk("R7 first released reused", int'(dec_pdst), 5);
    step(1, 0, 0, 1, 4, 0, 0, 0, 0, 1, 0);
    chk("R7 second released next", int'(dec_pdst), 6);

    // R8: checkpoint includes same-cycle decode, restore rewinds
    step(1, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    chk("R8 alloc after save", int'(dec_pdst), 7);
    step(1, 0, 0, 1, 5, 0, 0, 0, 0, 1, 1);
    chk("R8 restore stalls decode", int'(dec_stall), 1);
    step(1, 0, 4, 1, 0, 0, 0, 0, 0, 0, 0);
    chk("R8 map restored r0", int'(dec_psrc0), 0);
    chk("R8 saved mapping kept r4", int'(dec_psrc1), 6);
    chk("R8 head rewound", int'(dec_pdst), 7);

    // Random traffic against the reference model
    void'($urandom(32'h5EED_0B1E));
    for (int n = 0; n < 4000; n++) begin
      bit v, hd, wb, rel, sv, rs;
      int rp;
      v   = ($urandom % 4) != 0;
      hd  = ($urandom % 4) != 0;
      wb  = ($urandom % 2) != 0;
      rel = (pend.size() > 0) && (occ() < P) && (($urandom % 3) == 0);
      sv  = ($urandom % 20) == 0;
      rs  = ($urandom % 30) == 0;
      rp  = 0;
      if (rel) rp = pend.pop_front();
      step(v, int'($urandom % A), int'($urandom % A), hd, int'($urandom % A),
           wb, int'($urandom % P), rel, rp, sv, rs);
    end
    idle();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule